// File: doc/BRIEF.md
# Third-Bit Oversampled Serial Transceiver

This block moves bytes over a pair of asynchronous serial lines, one inbound and one outbound, and only one direction is active at a time. All of its timing comes from a single tick that runs at three times the bit rate. The tick comes from a divider on the system clock. A bit therefore lasts exactly three ticks. The receiver waits on the inbound line until it sees a low level. It then steps over the start bit and takes each data bit one tick into the bit. This puts every sample inside the middle third of the bit, whatever the phase of the tick against the incoming edge. The receiver reports the byte after only two ticks of the stop bit, which leaves time for a reply to be set up.

The transmitter takes a byte when it is idle and the receiver is not in the middle of a frame. It sends a low start bit, eight data bits least-significant first and a high stop bit, three ticks each. A flag is set when a start bit is detected. If that flag is still set when the next byte is accepted for sending, the flag is cleared and the transmitter waits two extra ticks before its start bit. This gives the far end time to turn its line around. Later sends have no such pad.

Receiver states: `RX_HUNT` (waiting for a start bit; moves to `RX_SKIP` on a tick that sees a low line, or to `RX_HOLD` when the transmitter claims the link), `RX_SKIP` (three ticks, then `RX_DATA`), `RX_DATA` (eight bits of three ticks, sampled on the first tick of each bit, then `RX_STOP`), `RX_STOP` (two ticks, then back to `RX_HUNT` with the valid strobe), `RX_HOLD` (line ignored; back to `RX_HUNT` when the transmitter is idle). Transmitter states: `TX_IDLE` (moves to `TX_PAD` on an accepted send), `TX_PAD` (waits for the next tick, plus two more if the turnaround flag was set, then `TX_START`), `TX_START`, `TX_DATA` and `TX_STOP` (three ticks per bit, after which it returns to `TX_IDLE`).

Top module: `tbs_serial`

## Requirements
- R1: The tick period is CLK_HZ/(3*BAUD) system clocks and every transmitted bit lasts three ticks. From the falling edge of the start bit to the fall of `tx_busy` is exactly 30 ticks.
- R2: `rx_hunting` is high while the receiver waits for a start bit, low from start detection until the byte is reported, and high again after that. In this state the synchronised line is examined once per tick.
- R3: A received byte is assembled least-significant bit first. `rx_data` takes the byte in the same cycle that `rx_valid` rises, and it holds the byte until the next report.
- R4: Each data bit is sampled once, on the first tick that follows the first third of the bit. Bits whose first and last thirds carry the opposite value are still received correctly.
- R5: `rx_valid` is a single-clock pulse. It is raised two ticks into the stop bit, that is 29 to 30 ticks after the falling edge of the start bit, and not at the end of a full stop bit.
- R6: The outbound frame is low for three ticks, then data bits 0 to 7 at three ticks each (line level equals the bit), then high for three ticks.
- R7: A start detection sets a turnaround flag. The first send accepted while the flag is set clears it and delays the start bit by two ticks beyond the next tick. Without the flag, the start bit begins on the first tick after acceptance.
- R8: `tx_send` is ignored while `tx_busy` is high or while the receiver is between start detection and its report. An ignored send leaves `tx_busy` low after the frame and does not change the received byte.
- R9: `tx_busy` rises on the clock after an accepted send and stays high through the pad and the stop bit. `tx_pin` is high whenever `tx_busy` is low.
- R10: While the transmitter is busy, the inbound line is ignored and no `rx_valid` is produced.
- R11: After reset `tx_pin` is high, `tx_busy` and `rx_valid` are low and `rx_hunting` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Inbound serial line, idle high |
| tx_pin | output | 1 | Outbound serial line, idle high |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | One-clock strobe for a new byte |
| rx_hunting | output | 1 | High while waiting for a start bit |
| tx_data | input | DATA_BITS | Byte to send, taken when a send is accepted |
| tx_send | input | 1 | Send request |
| tx_busy | output | 1 | Transmitter active (pad to end of stop bit) |

## Verification
The bench drives inbound bits whose outer thirds carry the inverse value. A receiver that samples at a bit edge, or counts the wrong number of skip ticks, would then return a corrupted byte. The bench times the receive strobe against the start edge, so a receiver that waits out a whole stop bit reports late and is caught. On the transmit side it measures the delay to the start edge, which separates padded replies from unpadded sends. A pad applied every time, or never, shows up there, and so does a flag that is not cleared. It also pokes `tx_send` during a busy frame and during an inbound frame. A design that accepted either would restart the line or corrupt the byte it was receiving.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int TICKS_PER_BIT = 3;
    localparam int RX_SKIP_TICKS = 3;
    localparam int RX_STOP_TICKS = 2;
    localparam int TX_PAD_TICKS  = 2;

    typedef enum logic [2:0] {
        RX_HOLD,
        RX_HUNT,
        RX_SKIP,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_PAD,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

endpackage

// File: rtl/tbs_tick_gen.sv
module tbs_tick_gen #(
    parameter int CLK_HZ        = 250_000_000,
    parameter int BAUD          = 2400,
    parameter int TICKS_PER_BIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_RAW = CLK_HZ / (BAUD * TICKS_PER_BIT);
    localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
    localparam int CW      = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV == 1) begin : g_every_clock
            assign tick = 1'b1;
        end else begin : g_divider
            logic [CW-1:0] cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == CW'(DIV - 1));

            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R1
        end
    endgenerate

endmodule

// File: rtl/tbs_rx.sv
module tbs_rx
    import tbs_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int TPB        = TICKS_PER_BIT,
    parameter int SKIP_TICKS = RX_SKIP_TICKS,
    parameter int STOP_TICKS = RX_STOP_TICKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_pin,
    input  logic                 hold,
    input  logic                 seen_clr,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 hunting,
    output logic                 seen
);
    localparam int TMAX_A = (SKIP_TICKS > TPB) ? SKIP_TICKS : TPB;
    localparam int TMAX   = (STOP_TICKS > TMAX_A) ? STOP_TICKS : TMAX_A;
    localparam int TCW    = $clog2(TMAX + 1);
    localparam int BW     = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    logic                 sync_a, line;
    rx_state_t            state, nxt;
    logic [TCW-1:0]       tcnt;
    logic [BW-1:0]        bidx;
    logic [DATA_BITS-1:0] shreg;

    // two-flop synchroniser, idle level high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            line   <= 1'b1;
        end else begin
            sync_a <= rx_pin;
            line   <= sync_a;
        end
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_HOLD: if (!hold) nxt = RX_HUNT;
            RX_HUNT: begin
                if (hold)                nxt = RX_HOLD;
                else if (tick && !line)  nxt = RX_SKIP;
            end
            RX_SKIP: if (tick && tcnt == TCW'(SKIP_TICKS - 1)) nxt = RX_DATA;
            RX_DATA: if (tick && tcnt == TCW'(TPB - 1) && bidx == BW'(DATA_BITS - 1))
                         nxt = RX_STOP;
            RX_STOP: if (tick && tcnt == TCW'(STOP_TICKS - 1)) nxt = RX_HUNT;
            default: nxt = RX_HOLD;
        endcase
    end

    // state register with tick and bit counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_HUNT;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
        end else begin
            state <= nxt;
            if (state != nxt) begin
                tcnt <= '0;
            end else if (tick && (state == RX_SKIP || state == RX_DATA || state == RX_STOP)) begin
                if (state == RX_DATA && tcnt == TCW'(TPB - 1)) begin
                    tcnt <= '0;
                    bidx <= bidx + 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
            if (state == RX_SKIP) begin
                bidx <= '0;
            end
            if (state == RX_DATA && tick && tcnt == '0) begin
                shreg <= {line, shreg[DATA_BITS-1:1]};
            end
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            seen     <= 1'b0;
        end else begin
            rx_valid <= (state == RX_STOP) && (nxt == RX_HUNT);
            if (state == RX_STOP && nxt == RX_HUNT) begin
                rx_data <= shreg;
            end
            if (state == RX_HUNT && nxt == RX_SKIP) begin
                seen <= 1'b1;
            end else if (seen_clr) begin
                seen <= 1'b0;
            end
        end
    end

    assign hunting = (state == RX_HUNT);

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5
    AST_RX_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD) |-> !rx_valid); // R10
    AST_RX_SEEN_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seen) |-> (state == RX_SKIP)); // R7

endmodule

// File: rtl/tbs_tx.sv
module tbs_tx
    import tbs_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int TPB       = TICKS_PER_BIT,
    parameter int PAD_TICKS = TX_PAD_TICKS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 send,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 pad_req,
    input  logic                 rx_idle,
    output logic                 tx_line,
    output logic                 busy,
    output logic                 accept
);
    localparam int TCW = $clog2(TPB + 1);
    localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam int PW  = (PAD_TICKS > 0) ? $clog2(PAD_TICKS + 1) : 1;

    tx_state_t            state, nxt;
    logic [TCW-1:0]       tcnt;
    logic [BW-1:0]        bidx;
    logic [PW-1:0]        pad_left;
    logic [DATA_BITS-1:0] shreg;

    assign accept = send && (state == TX_IDLE) && rx_idle;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE:  if (accept) nxt = TX_PAD;
            TX_PAD:   if (tick && pad_left == '0) nxt = TX_START;
            TX_START: if (tick && tcnt == TCW'(TPB - 1)) nxt = TX_DATA;
            TX_DATA:  if (tick && tcnt == TCW'(TPB - 1) && bidx == BW'(DATA_BITS - 1))
                          nxt = TX_STOP;
            TX_STOP:  if (tick && tcnt == TCW'(TPB - 1)) nxt = TX_IDLE;
            default:  nxt = TX_IDLE;
        endcase
    end

    // state register with counters and shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= TX_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            pad_left <= '0;
            shreg    <= '0;
        end else begin
            state <= nxt;
            if (accept) begin
                shreg    <= data;
                pad_left <= pad_req ? PW'(PAD_TICKS) : '0;
            end
            if (state == TX_PAD && tick && pad_left != '0) begin
                pad_left <= pad_left - 1'b1;
            end
            if (state == TX_START) begin
                bidx <= '0;
            end
            if (state != nxt) begin
                tcnt <= '0;
            end else if (tick && (state == TX_START || state == TX_DATA || state == TX_STOP)) begin
                if (state == TX_DATA && tcnt == TCW'(TPB - 1)) begin
                    tcnt  <= '0;
                    bidx  <= bidx + 1'b1;
                    shreg <= shreg >> 1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    // output process
    always_comb begin
        unique case (state)
            TX_START: tx_line = 1'b0;
            TX_DATA:  tx_line = shreg[0];
            default:  tx_line = 1'b1;
        endcase
    end

    assign busy = (state != TX_IDLE);

    AST_TX_BIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA && !tick) |=> $stable(tx_line)); // R6
    AST_TX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && send) |=> (state != TX_IDLE || $past(state) == TX_STOP)); // R8

endmodule

// File: rtl/tbs_serial.sv
module tbs_serial
    import tbs_pkg::*;
#(
    parameter int CLK_HZ    = 250_000_000,
    parameter int BAUD      = 2400,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_pin,
    output logic                 tx_pin,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 rx_hunting,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 tx_send,
    output logic                 tx_busy
);
    logic tick;
    logic accept;
    logic rx_seen;

    tbs_tick_gen #(
        .CLK_HZ       (CLK_HZ),
        .BAUD         (BAUD),
        .TICKS_PER_BIT(TICKS_PER_BIT)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    tbs_rx #(
        .DATA_BITS (DATA_BITS),
        .TPB       (TICKS_PER_BIT),
        .SKIP_TICKS(RX_SKIP_TICKS),
        .STOP_TICKS(RX_STOP_TICKS)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_pin  (rx_pin),
        .hold    (tx_busy | accept),
        .seen_clr(accept),
        .rx_data (rx_data),
        .rx_valid(rx_valid),
        .hunting (rx_hunting),
        .seen    (rx_seen)
    );

    tbs_tx #(
        .DATA_BITS(DATA_BITS),
        .TPB      (TICKS_PER_BIT),
        .PAD_TICKS(TX_PAD_TICKS)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .send   (tx_send),
        .data   (tx_data),
        .pad_req(rx_seen),
        .rx_idle(rx_hunting),
        .tx_line(tx_pin),
        .busy   (tx_busy),
        .accept (accept)
    );

    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !rx_valid); // R10
    AST_ACCEPT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (!rx_seen && tx_pin)); // R7
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && $past(!tx_busy)) |-> tx_pin); // R9

endmodule

// File: tb/tbs_serial_test.sv
`timescale 1ns/1ps
module tbs_serial_test;
    // 72 kHz nominal against 2400 baud gives ten clocks per tick
    localparam int D = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_send = 1'b0;
    logic       tx_pin, rx_valid, rx_hunting, tx_busy;
    logic [7:0] rx_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int vcount = 0, vtime = 0, vwide = 0, rx_edge = 0;
    logic [7:0] vdata = 8'h00;
    logic vprev = 1'b0;

    tbs_serial #(.CLK_HZ(72_000), .BAUD(2400), .DATA_BITS(8)) uut (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_pin(tx_pin),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_hunting(rx_hunting),
        .tx_data(tx_data), .tx_send(tx_send), .tx_busy(tx_busy)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rx_valid) begin
            if (vprev) vwide++;
            else begin
                vcount++;
                vtime = cyc;
                vdata = rx_data;
            end
        end
        vprev = rx_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic drive_rx(input logic [7:0] b, input bit garble);
        @(negedge clk);
        rx_pin = 1'b0;
        rx_edge = cyc;
        repeat (3*D) @(negedge clk);
        chk(rx_hunting == 1'b0, "R2 hunting low in frame", rx_hunting, 0);
        for (int k = 0; k < 8; k++) begin
            if (garble) begin
                rx_pin = ~b[k]; repeat (D-1) @(negedge clk);
                rx_pin = b[k];  repeat (D+3) @(negedge clk);
                rx_pin = ~b[k]; repeat (D-2) @(negedge clk);
            end else begin
                rx_pin = b[k];  repeat (3*D) @(negedge clk);
            end
        end
        rx_pin = 1'b1;
        repeat (3*D) @(negedge clk);
    endtask

    task automatic test_rx(input logic [7:0] b, input bit garble);
        int n0;
        n0 = vcount;
        drive_rx(b, garble);
        repeat (5) @(negedge clk);
        chk(vcount == n0 + 1, "R3 one byte reported", vcount - n0, 1);
        chk(vdata == b, garble ? "R4 middle-third sampling" : "R3 LSB-first byte", vdata, b);
        chk(rx_data == b, "R3 rx_data held", rx_data, b);
        chk(vtime - rx_edge >= 29*D && vtime - rx_edge <= 30*D + 3,
            "R5 strobe two ticks into stop", vtime - rx_edge, 29*D + 5);
        chk(vwide == 0, "R5 strobe one clock wide", vwide, 0);
        chk(rx_hunting == 1'b1, "R2 hunting after report", rx_hunting, 1);
    endtask

    task automatic test_tx(input logic [7:0] b, input bit expect_pad, input bit poke);
        int a, f, guard;
        @(negedge clk);
        tx_data = b;
        tx_send = 1'b1;
        a = cyc;
        @(negedge clk);
        tx_send = 1'b0;
        chk(tx_busy == 1'b1, "R9 busy after accept", tx_busy, 1);
        guard = 0;
        while (tx_pin && guard < 5*D) begin
            @(negedge clk);
            guard++;
        end
        f = cyc;
        if (expect_pad)
            chk(f - a >= 2*D + 2 && f - a <= 3*D + 1, "R7 turnaround pad", f - a, 2*D + 2);
        else
            chk(f - a >= 1 && f - a <= D + 1, "R7 no pad", f - a, D);
        wait_until(f + 15);
        chk(tx_pin == 1'b0, "R6 start bit low", tx_pin, 0);
        for (int k = 0; k < 8; k++) begin
            wait_until(f + 3*D*(k+1) + 15);
            chk(tx_pin == b[k], "R6 data bit", tx_pin, b[k]);
        end
        wait_until(f + 27*D + 15);
        chk(tx_pin == 1'b1, "R6 stop bit high", tx_pin, 1);
        if (poke) begin
            tx_data = ~b;
            tx_send = 1'b1;
            @(negedge clk);
            tx_send = 1'b0;
        end
        wait_until(f + 30*D - 1);
        chk(tx_busy == 1'b1, "R1 busy through stop", tx_busy, 1);
        wait_until(f + 30*D);
        chk(tx_busy == 1'b0, "R1 frame is 30 ticks", tx_busy, 0);
        if (poke) begin
            repeat (4*D) @(negedge clk);
            chk(tx_busy == 1'b0 && tx_pin == 1'b1, "R8 send while busy ignored", tx_busy, 0);
        end
        chk(tx_pin == 1'b1, "R9 idle line high", tx_pin, 1);
    endtask

    task automatic test_rx_during_tx();
        int n0;
        n0 = vcount;
        fork
            test_tx(8'h5A, 1'b0, 1'b0);
            begin
                repeat (20) @(negedge clk);
                rx_pin = 1'b0;
                repeat (4*D) @(negedge clk);
                rx_pin = 1'b1;
            end
        join
        repeat (40*D) @(negedge clk);
        chk(vcount == n0, "R10 inbound ignored while sending", vcount - n0, 0);
    endtask

    task automatic test_send_during_rx();
        int n0;
        n0 = vcount;
        fork
            drive_rx(8'h81, 1'b0);
            begin
                repeat (5*D) @(negedge clk);
                tx_data = 8'hEE;
                tx_send = 1'b1;
                @(negedge clk);
                tx_send = 1'b0;
                chk(tx_busy == 1'b0, "R8 send during receive ignored", tx_busy, 0);
            end
        join
        repeat (5) @(negedge clk);
        chk(vcount == n0 + 1 && vdata == 8'h81, "R8 receive intact", vdata, 8'h81);
        chk(tx_busy == 1'b0 && tx_pin == 1'b1, "R8 no frame started", tx_busy, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_pin == 1'b1, "R11 tx idle high", tx_pin, 1);
        chk(tx_busy == 1'b0, "R11 not busy", tx_busy, 0);
        chk(rx_valid == 1'b0, "R11 no strobe", rx_valid, 0);
        chk(rx_hunting == 1'b1, "R11 hunting", rx_hunting, 1);
        repeat (3*D) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        test_reset();
        test_tx(8'h96, 1'b0, 1'b1);
        test_rx(8'hA5, 1'b0);
        test_rx(8'h3C, 1'b1);
        test_tx(8'hC3, 1'b1, 1'b0);
        test_tx(8'h0F, 1'b0, 1'b0);
        test_rx_during_tx();
        test_send_during_rx();
        test_tx(8'h01, 1'b1, 1'b0);
        test_rx(8'h00, 1'b1);
        test_rx(8'hFF, 1'b0);
        finish_run();
    end

    initial begin
        repeat (150_000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

endmodule